// File: doc/BRIEF.md
# Sleep-Mode Wakeup Interrupt Monitor

This block stays powered while the main processor is asleep and watches a parameterised group of wakeup pins, 96 by default. Software programs each pin to fire on a rising edge, a falling edge, either edge, a high level or a low level. Each detected event sets a sticky status bit. The block raises one registered wake request whenever a status bit is set for a pin that is also enabled.

Software reaches the block through a word-addressed register space with 32-bit data. The first two words are plain timer storage. Five function banks follow them: enable, falling-edge select, rising-edge select, level polarity and status. Each bank is `ceil(PIN_COUNT/32)` words long. Before the processor sleeps, software clears the status words.

Top module: `wake_monitor`

## Requirements
- R1: After a synchronous reset, every stored register reads as zero except status, and `wake_o` and `rdata_o` are 0. The status bits of low pins in level-low mode set one cycle after reset.
- R2: Words 0 and 1 (byte addresses 0x0 and 0x4) are two independent 32-bit read/write storage words. A read returns data in `rdata_o` one cycle after `rd_en_i` is sampled, and `rdata_o` holds its value between reads.
- R3: Bank `b` word `i` sits at byte address `(b*N + i + 2)*4`, where `N = ceil(PIN_COUNT/32)`. The bank order is enable=0, falling=1, rising=2, polarity=3, status=4. Pin `p` is bit `p%32` of word `p/32` in each bank. Bits at or above PIN_COUNT read as 0 and ignore writes.
- R4: A read from an address past the last status word, or from an address whose two low bits are not zero, returns 0. A write to such an address changes no register.
- R5: A pin with rising=1 and falling=0 sets its status bit only when its synchronised value goes from 0 to 1.
- R6: A pin with rising=0 and falling=1 sets its status bit only when its synchronised value goes from 1 to 0.
- R7: A pin with both edge bits set sets its status bit on every change of its synchronised value. A pin with an edge bit set never sets status while its value is unchanged.
- R8: A pin with both edge bits clear is level-sensitive. Its status bit sets on every cycle that the synchronised pin equals its polarity bit (1 = active high, 0 = active low).
- R9: Status bits stay set until software writes the status word. The written value replaces the word, and a hit in the same cycle is ORed on top.
- R10: `wake_o` is the registered OR of (status AND enable) over all pins. A pin change applied before clock edge E0 reaches status at edge E2 and `wake_o` at edge E3, through a two-flop synchroniser. `wake_o` stays low while every enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | PIN_COUNT | Asynchronous wakeup pins |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| wake_o | output | 1 | Registered wake request |

## Verification
Most internal faults show up at the ports after a fixed, short delay.
- A wrong trigger decode or polarity shows as a wrong status word once a pin has changed, within three cycles.
- A wrong bank offset or stride shows as a read-back mismatch, or as a pin that reacts to the wrong configuration word.
- A lost enable or status bit shows on `wake_o` one cycle after status settles, and a synchroniser that is off by a stage shifts the edge at which `wake_o` rises.

The bench uses a 40-pin build, which has a partial top word. It sweeps every trigger mode across all pins in rotating assignments, and compares each status word and the wake level with values computed arithmetically.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int WORD_W      = 32;
  localparam int TIMER_WORDS = 2;
  localparam int NUM_BANKS   = 5;

  // Bank order matters: it fixes the address arithmetic software relies on.
  typedef enum logic [2:0] {
    BANK_EN   = 3'd0,
    BANK_FALL = 3'd1,
    BANK_RISE = 3'd2,
    BANK_POL  = 3'd3,
    BANK_STAT = 3'd4
  } bank_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= async_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = prev_q;

  // Any bit that changes in the second stage must have been sitting in the first.
  assert_sync_two_stage_R10: assert property (@(posedge clk) disable iff (rst)
    (((s2_q ^ $past(s2_q)) & ~($past(s1_q) ^ $past(s2_q))) == '0));
endmodule

// File: rtl/wake_trig_detect.sv
module wake_trig_detect #(
  parameter int W = 96
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] hit_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic edge_mode, rose, fell, lvl;
    assign edge_mode = rise_en_i[p] | fall_en_i[p];
    assign rose      = cur_i[p] & ~prev_i[p];
    assign fell      = ~cur_i[p] & prev_i[p];
    assign lvl       = ~(cur_i[p] ^ pol_i[p]);
    assign hit_o[p]  = edge_mode ? ((rise_en_i[p] & rose) | (fall_en_i[p] & fell)) : lvl;
  end
endmodule

// File: rtl/wake_regbank.sv
module wake_regbank
  import wake_pkg::*;
#(
  parameter int PIN_COUNT = 96,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic [PIN_COUNT-1:0] hit_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [PIN_COUNT-1:0] en_o,
  output logic [PIN_COUNT-1:0] fall_o,
  output logic [PIN_COUNT-1:0] rise_o,
  output logic [PIN_COUNT-1:0] pol_o,
  output logic [PIN_COUNT-1:0] stat_o
);
  localparam int NW      = (PIN_COUNT + WORD_W - 1) / WORD_W;
  localparam int PW      = NW * WORD_W;
  localparam int WORD_AW = ADDR_W - 2;

  logic [WORD_AW-1:0]   word;
  logic                 aligned, is_timer, in_map;
  logic [2:0]           bank_sel;
  int                   base;
  logic [NUM_BANKS-1:0] bank_we;
  logic [1:0]           timer_we;
  logic [WORD_W-1:0]    rd_word;
  logic [PW-1:0]        sel_pad;

  logic [PIN_COUNT-1:0] bank_q [NUM_BANKS];
  logic [WORD_W-1:0]    timer_q [TIMER_WORDS];
  logic [WORD_W-1:0]    rdata_q;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  // Address decode: timer words, then bank/word lookup by comparison.
  always_comb begin
    is_timer = aligned && (int'(word) < TIMER_WORDS);
    in_map   = 1'b0;
    bank_sel = 3'd0;
    base     = 0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < NW; i++) begin
        if (aligned && int'(word) == TIMER_WORDS + b * NW + i) begin
          in_map   = 1'b1;
          bank_sel = 3'(b);
          base     = i * WORD_W;
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      bank_we[b] = wr_en_i && in_map && (bank_sel == 3'(b));
    for (int t = 0; t < TIMER_WORDS; t++)
      timer_we[t] = wr_en_i && is_timer && (int'(word) == t);
  end

  function automatic logic [PIN_COUNT-1:0] merge_word(
    input logic [PIN_COUNT-1:0] old,
    input int                   pos,
    input logic [WORD_W-1:0]    d
  );
    logic [PW-1:0] pad;
    pad = PW'(old);
    pad[pos +: WORD_W] = d;
    return pad[PIN_COUNT-1:0];
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (b == int'(BANK_STAT)) begin : g_status
      // Sticky: software write replaces, fresh hits are ORed on top.
      logic [PIN_COUNT-1:0] base_v;
      assign base_v = bank_we[b] ? merge_word(bank_q[b], base, wdata_i) : bank_q[b];
      always_ff @(posedge clk) begin
        if (rst) bank_q[b] <= '0;
        else     bank_q[b] <= base_v | hit_i;
      end
    end else begin : g_config
      always_ff @(posedge clk) begin
        if (rst)             bank_q[b] <= '0;
        else if (bank_we[b]) bank_q[b] <= merge_word(bank_q[b], base, wdata_i);
      end
    end
  end

  for (genvar t = 0; t < TIMER_WORDS; t++) begin : g_timer
    always_ff @(posedge clk) begin
      if (rst)              timer_q[t] <= '0;
      else if (timer_we[t]) timer_q[t] <= wdata_i;
    end
  end

  always_comb begin
    sel_pad = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel == 3'(b)) sel_pad = PW'(bank_q[b]);
    if (is_timer)    rd_word = word[0] ? timer_q[1] : timer_q[0];
    else if (in_map) rd_word = sel_pad[base +: WORD_W];
    else             rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;
  assign en_o    = bank_q[BANK_EN];
  assign fall_o  = bank_q[BANK_FALL];
  assign rise_o  = bank_q[BANK_RISE];
  assign pol_o   = bank_q[BANK_POL];
  assign stat_o  = bank_q[BANK_STAT];

  assert_unmapped_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !in_map && !is_timer) |=> (rdata_o == '0));

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (!bank_we[BANK_STAT]) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  assert_timer_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i) |=> (timer_q[0] == $past(timer_q[0]) && timer_q[1] == $past(timer_q[1])));
endmodule

// File: rtl/wake_monitor.sv
module wake_monitor
  import wake_pkg::*;
#(
  parameter int PIN_COUNT = 96,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] pin_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic                 wake_o
);
  logic [PIN_COUNT-1:0] cur, prev, hit;
  logic [PIN_COUNT-1:0] en, fall, rise, pol, stat;
  logic [PIN_COUNT-1:0] pending, lvl_cond;
  logic                 wake_q;

  wake_sync #(.W(PIN_COUNT)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  wake_trig_detect #(.W(PIN_COUNT)) u_detect (
    .cur_i(cur), .prev_i(prev), .rise_en_i(rise), .fall_en_i(fall),
    .pol_i(pol), .hit_o(hit)
  );

  wake_regbank #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .hit_i(hit), .rdata_o(rdata_o),
    .en_o(en), .fall_o(fall), .rise_o(rise), .pol_o(pol), .stat_o(stat)
  );

  assign pending = stat & en;

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= |pending;
  end

  assign wake_o = wake_q;

  // Level condition as seen by the checks below (not used by the datapath).
  assign lvl_cond = ~(rise | fall) & ~(cur ^ pol);

  assert_edge_needs_change_R7: assert property (@(posedge clk) disable iff (rst)
    ((hit & (rise | fall) & ~(cur ^ prev)) == '0));

  assert_level_sets_status_R8: assert property (@(posedge clk) disable iff (rst)
    (lvl_cond != '0) |=> ((stat & $past(lvl_cond)) == $past(lvl_cond)));

  assert_no_enable_no_wake_R10: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !wake_o);
endmodule

// File: tb/wake_monitor_test.sv
`timescale 1ns/1ps
module wake_monitor_test;
  localparam int PINS = 40;
  localparam int AW   = 8;
  localparam int NW   = 2;
  localparam int W_EN = 2, W_FALL = 4, W_RISE = 6, W_POL = 8, W_STAT = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic [PINS-1:0] pins;
  logic            wr_en, rd_en;
  logic [AW-1:0]   addr;
  logic [31:0]     wdata, rdata;
  logic            wake;

  always #2.5 clk = ~clk;

  wake_monitor #(.PIN_COUNT(PINS), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wake_o(wake)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(w * 4); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_addr(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rd(input int w, output logic [31:0] d);
    rd_addr(AW'(w * 4), d);
  endtask

  function automatic logic [PINS-1:0] next_pat();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng[PINS-1:0];
  endfunction

  task automatic wr_vec(input int w0, input logic [PINS-1:0] v);
    logic [63:0] p;
    p = 64'(v);
    wr(w0, p[31:0]);
    wr(w0 + 1, p[63:32]);
  endtask

  initial begin
    logic [31:0] d;
    logic [PINS-1:0] rise_m, fall_m, pol_m, en_m, po, pn, lv, ed, ex;
    logic [63:0] ex64;
    rst = 1; pins = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    check("R1 wake after reset", 32'(wake), 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    for (int w = 0; w < W_STAT; w++) begin
      rd(w, d);
      check("R1 config word zero", d, 32'h0);
    end
    // Defaults give level-low on every pin; pins are low.
    rd(W_STAT, d);     check("R8 level-low status w0", d, 32'hFFFF_FFFF);
    rd(W_STAT + 1, d); check("R3 partial status w1", d, 32'h0000_00FF);
    check("R10 no enable no wake", 32'(wake), 32'h0);

    // R2 timers
    wr(0, 32'hA5A5_0001); wr(1, 32'h1234_5678);
    rd(0, d); check("R2 timer0", d, 32'hA5A5_0001);
    rd(1, d); check("R2 timer1", d, 32'h1234_5678);

    // R3 bank words and partial top word
    wr(W_EN + 1, 32'hFFFF_FFFF);
    rd(W_EN + 1, d); check("R3 upper bits ignored", d, 32'h0000_00FF);
    wr(W_POL, 32'h3C3C_00F1);
    rd(W_POL, d); check("R3 polarity word", d, 32'h3C3C_00F1);
    wr(W_EN + 1, 0); wr(W_POL, 0);

    // R4 unmapped and misaligned
    wr(12, 32'hDEAD_BEEF); wr(63, 32'hDEAD_BEEF);
    rd(12, d); check("R4 unmapped word 12", d, 32'h0);
    rd(63, d); check("R4 unmapped word 63", d, 32'h0);
    rd_addr(AW'(1), d); check("R4 misaligned read", d, 32'h0);
    rd(0, d); check("R4 timer untouched", d, 32'hA5A5_0001);
    rd(W_EN, d); check("R4 enable untouched", d, 32'h0);

    // R10 latency: pin 0 rising, enabled
    wr_vec(W_RISE, '1); wr_vec(W_FALL, '0); wr_vec(W_POL, '0);
    wr_vec(W_EN, PINS'(1));
    wr_vec(W_STAT, '0);
    repeat (2) @(negedge clk);
    check("R10 wake low before edge", 32'(wake), 32'h0);
    pins[0] = 1'b1;              // before edge E0
    repeat (3) @(negedge clk);   // after E0, E1, E2
    check("R10 wake still low at E2", 32'(wake), 32'h0);
    @(negedge clk);
    check("R10 wake high at E3", 32'(wake), 32'h1);
    wr(W_STAT, 0);
    check("R9 wake before clear seen", 32'(wake), 32'h1);
    @(negedge clk);
    check("R9 wake drops after clear", 32'(wake), 32'h0);
    pins[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(W_STAT, d); check("R5 falling ignored on rise pin", d, 32'h0);
    wr(W_STAT, 32'h0000_0005);
    rd(W_STAT, d); check("R9 write replaces status", d, 32'h0000_0005);

    // Mode sweep: mode(p) = (3p + r) % 5
    // 0 rise, 1 fall, 2 both, 3 level-high, 4 level-low
    for (int r = 0; r < 5; r++) begin
      rise_m = '0; fall_m = '0; pol_m = '0;
      for (int p = 0; p < PINS; p++) begin
        int m;
        m = (3 * p + r) % 5;
        rise_m[p] = (m == 0) || (m == 2);
        fall_m[p] = (m == 1) || (m == 2);
        pol_m[p]  = (m == 3);
      end
      en_m = next_pat();
      if (r == 4) en_m = '0;
      wr_vec(W_RISE, rise_m); wr_vec(W_FALL, fall_m);
      wr_vec(W_POL, pol_m);   wr_vec(W_EN, en_m);
      po = next_pat();
      @(negedge clk); pins = po;
      repeat (5) @(negedge clk);
      wr_vec(W_STAT, '0);
      for (int k = 0; k < 4; k++) begin
        pn = next_pat();
        @(negedge clk); pins = pn;
        repeat (4) @(negedge clk);
        lv = ~(rise_m | fall_m) & (~(po ^ pol_m) | ~(pn ^ pol_m));
        ed = (rise_m & ~po & pn) | (fall_m & po & ~pn);
        ex = lv | ed;
        ex64 = 64'(ex);
        rd(W_STAT, d);     check("R5 R6 R7 R8 status word0", d, ex64[31:0]);
        rd(W_STAT + 1, d); check("R5 R6 R7 R8 status word1", d, ex64[63:32]);
        check("R10 wake level", 32'(wake), 32'(|(ex & en_m)));
        wr_vec(W_STAT, '0);
        po = pn;
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule